// File: doc/BRIEF.md
# Edge-Triggered Input Capture Latch

This block timestamps events on an external input. It passes the input through a synchronizer and watches it for one chosen transition, rising or falling. When that transition appears, it copies the value of a 12-bit free-running up-counter into a capture register that software can only read, and it raises a pending flag. The block can also request an interrupt. The counter is generated elsewhere and arrives as an input.

Software reads the captured value through two byte-wide read strobes. The low-byte strobe returns counter bits 7:0. The high-byte strobe returns bits 11:8 with zeros above them. The pending flag acts as a lock. While it is set, the block ignores further transitions, so the register keeps the value of the first event that was accepted. A read of the low byte while the flag is set releases the lock. Software should therefore read the high byte first and the low byte last.

Top module: `capture_latch`

## Requirements
- R1: After reset, `cap_flag` and `irq` are 0, the capture register holds 0, and `rd_data` is 0 whenever neither read strobe is high.
- R2: With `edge_fall` = 0, suppose the pin is sampled 1 at clock edge k and was sampled 0 at edge k-1. If the flag is clear, then at edge k+2 the register loads the `cnt_val` present at that edge and `cap_flag` becomes 1.
- R3: With `edge_fall` = 1, the same timing applies to a sample of 0 at edge k after a sample of 1 at edge k-1.
- R4: `irq` is 1 exactly when `cap_flag` is 1 and `irq_en` is 1.
- R5: While `cap_flag` is 1, any transition on the pin is ignored, and the capture register keeps its value.
- R6: A clock edge at which `rd_lo` is 1 while `cap_flag` is 1 clears `cap_flag`.
- R7: `rd_lo` = 1 makes `rd_data` return register bits 7:0. Otherwise `rd_hi` = 1 returns bits 11:8 in `rd_data[3:0]` with `rd_data[7:4]` = 0. A high-byte read never clears the flag.
- R8: If a selected transition is recognised at the same edge as a clearing low-byte read, the flag ends up 0 and that transition is not captured.
- R9: A transition of the polarity that is not selected is never captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 1 | External capture input, asynchronous |
| cnt_val | input | 12 | Free-running counter value |
| edge_fall | input | 1 | 0 selects the rising edge, 1 selects the falling edge |
| irq_en | input | 1 | Interrupt enable |
| rd_lo | input | 1 | Read strobe for the low byte; clears the flag |
| rd_hi | input | 1 | Read strobe for the high byte |
| rd_data | output | 8 | Read data, combinational from the strobes |
| cap_flag | output | 1 | Capture pending |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is R8, where a clearing read lands on the same edge at which a synchronized transition is recognised. From the ports this needs the pin to be changed exactly two clocks before the read strobe. The stimulus first sets the flag. It then moves the pin and raises `rd_lo` at the clock that matches the synchronizer delay. Afterwards it confirms that the flag stays clear. The lockout case of R5 is reached by toggling the pin repeatedly while a capture is still pending, with a counter that keeps running. Any late capture would then show up as a changed register value.

// File: rtl/capture_latch.sv
module capture_latch #(
  parameter int CNT_W       = 12,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_pin,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              edge_fall,
  input  logic              irq_en,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [DATA_W-1:0] rd_data,
  output logic              cap_flag,
  output logic              irq
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_prev;
  logic [CNT_W-1:0]       cap_q;
  logic                   pin_s, hit, clr, take;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign hit   = edge_fall ? (pin_prev & ~pin_s) : (pin_s & ~pin_prev);
  assign clr   = rd_lo & cap_flag;
  assign take  = hit & ~cap_flag;
  assign irq   = cap_flag & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      pin_prev <= 1'b0;
      cap_q    <= '0;
      cap_flag <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], cap_pin};
      pin_prev <= pin_s;
      if (clr) begin
        cap_flag <= 1'b0;
      end else if (take) begin
        cap_flag <= 1'b1;
        cap_q    <= cnt_val;
      end
    end
  end

  always_comb begin
    if (rd_lo)
      rd_data = cap_q[DATA_W-1:0];
    else if (rd_hi)
      rd_data = {{PAD_W{1'b0}}, cap_q[CNT_W-1:DATA_W]};
    else
      rd_data = '0;
  end
endmodule

module capture_latch_chk #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              irq_en,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic [DATA_W-1:0] rd_data,
  input logic              cap_flag,
  input logic              irq,
  input logic [CNT_W-1:0]  cap_q
);
  localparam int HI_W = CNT_W - DATA_W;

  p_value_on_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> cap_q == $past(cnt_val));

  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cap_flag && irq_en));

  p_lockout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag |=> $stable(cap_q));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !rd_lo) |=> cap_flag);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && rd_lo) |=> !cap_flag);

  p_hi_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rd_lo) |-> rd_data[DATA_W-1:HI_W] == '0);
endmodule

bind capture_latch capture_latch_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .irq_en(irq_en),
  .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data), .cap_flag(cap_flag),
  .irq(irq), .cap_q(cap_q)
);

// File: tb/tb_capture_latch.sv
module tb_capture_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0;
  logic [11:0] cnt_val = 12'hFF0;
  logic        edge_fall = 1'b0;
  logic        irq_en = 1'b0;
  logic        rd_lo = 1'b0;
  logic        rd_hi = 1'b0;
  logic [7:0]  rd_data;
  logic        cap_flag;
  logic        irq;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  int m_cap = 0;
  int m_flag = 0;
  int hist[$] = '{0, 0, 0};

  always #5 clk = ~clk;

  capture_latch dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .cnt_val(cnt_val),
    .edge_fall(edge_fall), .irq_en(irq_en), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rd_data(rd_data), .cap_flag(cap_flag), .irq(irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: a pin sample pipeline and the flag/lock rules
  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_cap = 0;
      m_flag = 0;
    end else begin
      bit ev;
      ev = edge_fall ? (hist[1] == 0 && hist[2] == 1) : (hist[1] == 1 && hist[2] == 0);
      if (rd_lo && m_flag == 1) m_flag = 0;
      else if (m_flag == 0 && ev) begin
        m_flag = 1;
        m_cap = int'(cnt_val);
      end
      hist.push_front(int'(cap_pin));
      void'(hist.pop_back());
    end
  end

  always begin
    @(negedge clk);
    #2;
    if (rst_n && !finished) begin
      int exp_rd;
      if (rd_lo) exp_rd = m_cap % 256;
      else if (rd_hi) exp_rd = m_cap / 256;
      else exp_rd = 0;
      chk(cur_req, "rd_data", int'(rd_data), exp_rd);
      chk(cur_req, "cap_flag", int'(cap_flag), m_flag);
      chk("R4", "irq", int'(irq), (m_flag == 1 && irq_en) ? 1 : 0);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cnt_val = cnt_val + 12'd7;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(bit v);
    @(negedge clk);
    cap_pin = v;
  endtask

  task automatic pulse_lo();
    @(negedge clk);
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
  endtask

  task automatic pulse_hi();
    @(negedge clk);
    rd_hi = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0;
  endtask

  initial begin
    int saved;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    #2;
    chk("R1", "reset flag", int'(cap_flag), 0);
    chk("R1", "reset irq", int'(irq), 0);
    chk("R1", "reset rd_data", int'(rd_data), 0);

    cur_req = "R2";
    set_pin(1'b1);
    idle(5);
    #2;
    chk("R2", "flag after rise", int'(cap_flag), 1);
    cur_req = "R7";
    pulse_hi();
    #2;
    chk("R7", "flag after hi read", int'(cap_flag), 1);
    cur_req = "R6";
    pulse_lo();
    #2;
    chk("R6", "flag after lo read", int'(cap_flag), 0);

    cur_req = "R9";
    irq_en = 1'b1;
    set_pin(1'b0);
    idle(5);
    #2;
    chk("R9", "falling ignored", int'(cap_flag), 0);

    cur_req = "R4";
    set_pin(1'b1);
    idle(5);
    #2;
    chk("R4", "irq on capture", int'(irq), 1);
    saved = m_cap;

    cur_req = "R5";
    set_pin(1'b0);
    idle(2);
    set_pin(1'b1);
    idle(2);
    set_pin(1'b0);
    idle(2);
    set_pin(1'b1);
    idle(5);
    @(negedge clk);
    rd_lo = 1'b1;
    #2;
    chk("R5", "locked low byte", int'(rd_data), saved % 256);
    @(negedge clk);
    rd_lo = 1'b0;

    cur_req = "R3";
    edge_fall = 1'b1;
    set_pin(1'b0);
    idle(5);
    #2;
    chk("R3", "flag after fall", int'(cap_flag), 1);
    pulse_hi();
    pulse_lo();

    cur_req = "R8";
    edge_fall = 1'b0;
    set_pin(1'b1);
    idle(5);
    set_pin(1'b0);
    idle(5);
    #2;
    chk("R8", "flag set before race", int'(cap_flag), 1);
    set_pin(1'b1);
    idle(2);
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
    idle(6);
    #2;
    chk("R8", "edge dropped on clear", int'(cap_flag), 0);

    cur_req = "R4";
    irq_en = 1'b0;
    set_pin(1'b0);
    set_pin(1'b1);
    idle(5);
    #2;
    chk("R4", "flag without enable", int'(cap_flag), 1);
    chk("R4", "irq masked", int'(irq), 0);
    pulse_lo();
    idle(3);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule